// File: doc/BRIEF.md
# Banked RAM and ROM Chip-Select Decoder

This block is the memory behind a small CPU bus. The CPU drives a 10-bit byte address, an 8-bit write value, and read and write strobes. The block splits the address space into four 128-byte RAM banks and one 512-byte ROM.

A decoder turns the upper address bits into a pair of chip-select signals for each device. A device responds only when its first select is high and its second select is low. The shared data bus is bidirectional. It is modelled as a separate write-data input, a read-data output and an output enable. When the enable is low, the read-data output is held at zero. That zero stands for the high-impedance state of a real bus.

RAM writes take effect on the rising clock edge. Reads are combinational from the stored array. The ROM contents come from a fixed formula that is set by a seed parameter. The ROM has no write path.

Top module: `mem_select_top`

## Requirements
- R1: Addresses 0x000–0x1FF reach RAM. Address bits 8:7 pick the bank: 0 for 0x000–0x07F, 1 for 0x080–0x0FF, 2 for 0x100–0x17F and 3 for 0x180–0x1FF. Bits 6:0 pick the byte in that bank, and each bank keeps its own bytes.
- R2: Addresses 0x200–0x3FF, where bit 9 is high, reach the ROM, and bits 8:0 give the offset k. The byte at offset k is (3·k + 0x55·(k>>8) + SEED) mod 256, with the default SEED = 0x1D.
- R3: A device is active only while its first chip-select is 1 and its second is 0. At most one device is active for any address, and an inactive device never drives the bus.
- R4: With RD=1, the addressed device is read whatever WR is. When RD and WR are both high, no write takes place.
- R5: With RD=0 and WR=1, the write value is stored into the addressed RAM byte on the rising clock edge. A read of that byte in the next cycle returns it.
- R6: With RD=0 and WR=0, the bus is idle: the output enable is 0, the output data is 0x00, and no storage changes.
- R7: A write aimed at the ROM range changes no ROM byte and no RAM byte.
- R8: The output enable is 1 only while RD is 1. While the enable is 0, the output data is 0x00.
- R9: A synchronous active-low reset clears every RAM byte to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; RAM writes happen on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears all RAM |
| addr | input | 10 | CPU byte address |
| wdata | input | 8 | Write value from the CPU side of the data bus |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| rdata | output | 8 | Read value driven onto the data bus; 0x00 when not driving |
| rdata_oe | output | 1 | Bus output enable; high only during a read |

## Verification
Each fault shows up at the ports in a set time:
- A wrong decoder select shows in the same cycle. The read returns another bank's byte, or the enable stays low on a read.
- A corrupted RAM cell, or a write let through on a simultaneous read, shows on the first read of that byte after the faulty edge.
- A write that leaks into the wrong bank or into the ROM region is caught by read-backs of bytes that were never written.
- A ROM formula error appears on any ROM read.

// File: rtl/msel_pkg.sv
// Package: shared helpers for the banked memory subsystem.
// Assumes: callers truncate the returned value to their data width.
package msel_pkg;

    // Fixed ROM content formula: byte at offset k.
    function automatic int unsigned rom_byte(input int unsigned k, input int unsigned seed);
        int unsigned v;
        v = 3 * k + 32'h55 * (k >> 8) + seed;
        return v & 32'hFF;
    endfunction

endpackage

// File: rtl/msel_decode.sv
// Module: msel_decode
// Turns the bank index and the ROM-region bit into per-device chip-select
// pairs. A device counts as active when cs1=1 and cs2=0.
// Assumes: RAM_BANKS is a power of two matching BANK_SEL_W.
module msel_decode #(
    parameter int RAM_BANKS  = 4,
    parameter int BANK_SEL_W = 2
) (
    input  logic [BANK_SEL_W-1:0] bank_idx,
    input  logic                  rom_region,
    output logic [RAM_BANKS-1:0]  ram_cs1,
    output logic [RAM_BANKS-1:0]  ram_cs2,
    output logic                  rom_cs1,
    output logic                  rom_cs2
);

    // 2-to-N decode of the bank index onto each RAM's first select.
    always_comb begin
        for (int i = 0; i < RAM_BANKS; i++) begin
            ram_cs1[i] = (bank_idx == BANK_SEL_W'(i));
            ram_cs2[i] = rom_region;
        end
    end

    // The ROM is enabled by the region bit; its second select is tied inactive.
    assign rom_cs1 = rom_region;
    assign rom_cs2 = 1'b0;

    // R3
    always_comb begin
        if (!$isunknown({bank_idx, rom_region})) begin
            dev_sel_onehot_chk: assert ($onehot0({ram_cs1 & ~ram_cs2, rom_cs1 & ~rom_cs2}))
                else $error("more than one device selected");
        end
    end

endmodule

// File: rtl/msel_ram_bank.sv
// Module: msel_ram_bank
// One RAM bank with two chip selects. It is active when cs1=1 and cs2=0.
// A read wins over a write. Writes land on the rising edge; reads are
// combinational. The synchronous active-low reset clears every byte.
// Assumes: rd and wr are active high and stable around the clock edge.
module msel_ram_bank #(
    parameter int DATA_W = 8,
    parameter int AW     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs1,
    input  logic              cs2,
    input  logic              rd,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              oe
);

    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              active;
    logic              do_write;

    // Chip-select truth table: only cs1=1, cs2=0 enables the bank.
    assign active   = cs1 && !cs2;
    // Write only when selected, write strobe high and read strobe low.
    assign do_write = active && wr && !rd;

    // Storage update: clear on reset, otherwise a single-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (do_write) begin
            mem[addr] <= din;
        end
    end

    // Read path: drive the addressed byte only while reading.
    always_comb begin
        oe   = active && rd;
        dout = oe ? mem[addr] : '0;
    end

    // R5
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(do_write) && active && rd && addr == $past(addr))
        |-> dout == $past(din));

    // R4
    rd_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(active && rd && wr) && active && rd && addr == $past(addr))
        |-> dout == $past(dout));

    // R3
    inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs1 && !cs2) |-> (!oe && dout == '0));

endmodule

// File: rtl/msel_rom.sv
// Module: msel_rom
// Read-only bank with two chip selects. It is active when cs1=1 and cs2=0.
// Its contents come from a fixed formula set by a seed, and it has no
// write port.
// Assumes: the clock and reset are used only by the local checks.
module msel_rom #(
    parameter int          DATA_W = 8,
    parameter int          AW     = 9,
    parameter int unsigned SEED   = 32'h1D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs1,
    input  logic              cs2,
    input  logic              rd,
    input  logic [AW-1:0]     addr,
    output logic [DATA_W-1:0] dout,
    output logic              oe
);

    import msel_pkg::*;

    logic              active;
    logic [DATA_W-1:0] word;

    // Chip-select truth table, as for the RAM banks.
    assign active = cs1 && !cs2;

    // Content lookup: evaluate the formula at the given offset.
    always_comb begin
        word = DATA_W'(rom_byte(32'(addr), SEED));
    end

    // Read path: drive only while selected and reading.
    always_comb begin
        oe   = active && rd;
        dout = oe ? word : '0;
    end

    // R7
    rom_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(oe) && oe && addr == $past(addr)) |-> $stable(dout));

endmodule

// File: rtl/mem_select_top.sv
// Module: mem_select_top
// A CPU-facing memory made of RAM_BANKS RAM banks and one ROM, selected
// from the byte address. The bidirectional data bus is split into wdata,
// rdata and rdata_oe; rdata is zero whenever rdata_oe is low.
// Assumes: ROM_AW + 1 == RAM_AW + log2(RAM_BANKS) + 1, so the RAM region
// fills exactly the lower half of the address space.
module mem_select_top #(
    parameter int          DATA_W    = 8,
    parameter int          RAM_AW    = 7,
    parameter int          RAM_BANKS = 4,
    parameter int          ROM_AW    = 9,
    parameter int unsigned ROM_SEED  = 32'h1D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROM_AW:0]   addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    input  logic              wr,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);

    localparam int BANK_SEL_W = $clog2(RAM_BANKS);
    localparam int ADDR_W     = ROM_AW + 1;
    localparam int REGION_BIT = ADDR_W - 1;

    logic [RAM_BANKS-1:0] ram_cs1;
    logic [RAM_BANKS-1:0] ram_cs2;
    logic                 rom_cs1;
    logic                 rom_cs2;
    logic [DATA_W-1:0]    bank_dout [RAM_BANKS];
    logic [RAM_BANKS-1:0] bank_oe;
    logic [DATA_W-1:0]    rom_dout;
    logic                 rom_oe;

    msel_decode #(
        .RAM_BANKS (RAM_BANKS),
        .BANK_SEL_W(BANK_SEL_W)
    ) i_decode (
        .bank_idx  (addr[RAM_AW +: BANK_SEL_W]),
        .rom_region(addr[REGION_BIT]),
        .ram_cs1   (ram_cs1),
        .ram_cs2   (ram_cs2),
        .rom_cs1   (rom_cs1),
        .rom_cs2   (rom_cs2)
    );

    for (genvar b = 0; b < RAM_BANKS; b++) begin : g_bank
        msel_ram_bank #(
            .DATA_W(DATA_W),
            .AW    (RAM_AW)
        ) i_bank (
            .clk (clk),
            .rst_n(rst_n),
            .cs1 (ram_cs1[b]),
            .cs2 (ram_cs2[b]),
            .rd  (rd),
            .wr  (wr),
            .addr(addr[RAM_AW-1:0]),
            .din (wdata),
            .dout(bank_dout[b]),
            .oe  (bank_oe[b])
        );
    end

    msel_rom #(
        .DATA_W(DATA_W),
        .AW    (ROM_AW),
        .SEED  (ROM_SEED)
    ) i_rom (
        .clk  (clk),
        .rst_n(rst_n),
        .cs1  (rom_cs1),
        .cs2  (rom_cs2),
        .rd   (rd),
        .addr (addr[ROM_AW-1:0]),
        .dout (rom_dout),
        .oe   (rom_oe)
    );

    // Bus merge: each device outputs zero when not driving, so OR them.
    always_comb begin
        rdata = rom_dout;
        for (int b = 0; b < RAM_BANKS; b++) rdata = rdata | bank_dout[b];
        rdata_oe = rom_oe || (|bank_oe);
    end

    // R8
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> rd);

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> rdata == '0);

    // R1
    read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> rdata_oe);

endmodule

// File: tb/test_mem_select_top.sv
// Bench: a vector table walked by one loop, then directed reset checks.
// Inputs change on the falling edge; outputs are sampled 2 ns later.
module test_mem_select_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] rdata;
    logic       rdata_oe;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    mem_select_top i_mem_select_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rd(rd), .wr(wr), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    // Field order: {req, rd, wr, addr, wdata, exp_oe, exp_data}
    localparam int NV = 21;
    localparam logic [32:0] VEC [NV] = '{
        {4'd9, 1'b1, 1'b0, 10'h000, 8'h00, 1'b1, 8'h00}, // R9 cleared after reset
        {4'd5, 1'b0, 1'b1, 10'h000, 8'hA1, 1'b0, 8'h00}, // R5 write bank 0
        {4'd5, 1'b1, 1'b0, 10'h000, 8'h00, 1'b1, 8'hA1}, // R5 read back
        {4'd8, 1'b0, 1'b1, 10'h080, 8'hB2, 1'b0, 8'h00}, // R8 write bank 1, no drive
        {4'd1, 1'b0, 1'b1, 10'h100, 8'hC3, 1'b0, 8'h00}, // R1 write bank 2
        {4'd1, 1'b0, 1'b1, 10'h1FF, 8'hD4, 1'b0, 8'h00}, // R1 write bank 3 top
        {4'd1, 1'b1, 1'b0, 10'h080, 8'h00, 1'b1, 8'hB2}, // R1
        {4'd1, 1'b1, 1'b0, 10'h100, 8'h00, 1'b1, 8'hC3}, // R1
        {4'd1, 1'b1, 1'b0, 10'h1FF, 8'h00, 1'b1, 8'hD4}, // R1
        {4'd3, 1'b1, 1'b0, 10'h07F, 8'h00, 1'b1, 8'h00}, // R3 no cross-bank leak
        {4'd3, 1'b1, 1'b0, 10'h180, 8'h00, 1'b1, 8'h00}, // R3
        {4'd4, 1'b1, 1'b1, 10'h080, 8'h55, 1'b1, 8'hB2}, // R4 read wins
        {4'd4, 1'b1, 1'b0, 10'h080, 8'h00, 1'b1, 8'hB2}, // R4 no write happened
        {4'd6, 1'b0, 1'b0, 10'h080, 8'h77, 1'b0, 8'h00}, // R6 idle
        {4'd6, 1'b1, 1'b0, 10'h080, 8'h00, 1'b1, 8'hB2}, // R6 unchanged
        {4'd7, 1'b0, 1'b1, 10'h200, 8'hFF, 1'b0, 8'h00}, // R7 write to ROM range
        {4'd7, 1'b1, 1'b0, 10'h200, 8'h00, 1'b1, 8'h1D}, // R7 ROM offset 0 intact
        {4'd2, 1'b1, 1'b0, 10'h3FF, 8'h00, 1'b1, 8'h6F}, // R2 offset 0x1FF
        {4'd2, 1'b1, 1'b0, 10'h300, 8'h00, 1'b1, 8'h72}, // R2 offset 0x100
        {4'd2, 1'b1, 1'b0, 10'h205, 8'h00, 1'b1, 8'h2C}, // R2 offset 5
        {4'd7, 1'b1, 1'b0, 10'h000, 8'h00, 1'b1, 8'hA1}  // R7 RAM alias untouched
    };

    // Compare the bus against expectations and log a miscompare.
    task automatic check(input int req, input logic exp_oe, input logic [7:0] exp_d);
        n_chk++;
        if (rdata_oe !== exp_oe || rdata !== exp_d) begin
            n_bad++;
            $display("FAIL R%0d: addr=%03h oe=%0b data=%02h expected oe=%0b data=%02h",
                     req, addr, rdata_oe, rdata, exp_oe, exp_d);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 check(9, 1'b0, 8'h00); // R9 bus quiet while held in reset
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {rd, wr, addr, wdata} = {VEC[i][28], VEC[i][27], VEC[i][26:17], VEC[i][16:9]};
            #2 check(int'(VEC[i][32:29]), VEC[i][8], VEC[i][7:0]);
        end
        // R9: a mid-run reset clears the written bytes
        @(negedge clk);
        rd = 1'b0; wr = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; rd = 1'b1; addr = 10'h000;
        #2 check(9, 1'b1, 8'h00);
        @(negedge clk);
        addr = 10'h1FF;
        #2 check(9, 1'b1, 8'h00);
        // R5: back-to-back writes to adjacent bytes of one bank
        @(negedge clk);
        rd = 1'b0; wr = 1'b1; addr = 10'h17E; wdata = 8'h3C;
        @(negedge clk);
        addr = 10'h17F; wdata = 8'h4D;
        @(negedge clk);
        wr = 1'b0; rd = 1'b1; addr = 10'h17E;
        #2 check(5, 1'b1, 8'h3C);
        @(negedge clk);
        addr = 10'h17F;
        #2 check(5, 1'b1, 8'h4D);
        @(negedge clk);
        rd = 1'b0;
        #2 check(8, 1'b0, 8'h00); // R8 released when the read ends
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run still active (actual running, expected done)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule